// File: doc/BRIEF.md
# Event-Number Mapped Condition Bits

This block keeps a 15-bit condition word whose bit meanings are assigned by software. Internal occurrences reach it as numbered events, at most one number per strobe. Each condition bit has two programmable numbers. One is the number that sets the bit, and the other is the number that clears it. When a strobe carries a number, every bit with a matching set number goes to 1 and every bit with a matching clear number goes to 0. All other bits keep their value.

The condition word feeds a status register group downstream. Software loads the mapping through a write port and reads it back through a combinational read port. Number zero marks a slot as unmapped.

Top module: `evmap_cond`

## Requirements
- R1: After reset, `cond_o` is all zero and every set and clear entry reads back as 0.
- R2: A write with `cfg_we_i` high stores `cfg_wdata_i` into the entry of bit `cfg_widx_i`. `cfg_wsel_i`=0 selects the set number and 1 selects the clear number. The new value is visible on `cfg_rdata_o` from the cycle after the write edge. The read port is combinational in `cfg_ridx_i`/`cfg_rsel_i`, which use the same encoding.
- R3: A strobe whose number equals a bit's non-zero set number makes that bit 1 in the cycle after the strobe edge.
- R4: A strobe whose number equals a bit's non-zero clear number, and not its set number, makes that bit 0 in the cycle after the strobe edge.
- R5: Event number 0 never matches any entry, so a strobe with number 0 leaves `cond_o` unchanged.
- R6: If a bit's set and clear numbers are equal and that number arrives, the bit becomes 1.
- R7: One strobe updates every matching bit in the same cycle.
- R8: Bits whose entries do not match the strobe keep their value. With `ev_valid_i` low, `cond_o` is unchanged.
- R9: Writes to an index of 15 or more are ignored. Reads of such an index return 0.
- R10: A strobe in the same cycle as a table write is matched against the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write enable |
| cfg_widx_i | input | 4 | Condition bit index for the write |
| cfg_wsel_i | input | 1 | 0 writes the set number, 1 writes the clear number |
| cfg_wdata_i | input | 16 | Event number to store |
| cfg_ridx_i | input | 4 | Condition bit index for the read |
| cfg_rsel_i | input | 1 | 0 reads the set number, 1 reads the clear number |
| cfg_rdata_o | output | 16 | Stored event number for the selected entry |
| ev_valid_i | input | 1 | Event strobe |
| ev_num_i | input | 16 | Event number carried by the strobe |
| cond_o | output | 15 | Condition word |

## Verification
The bench covers several corner cases, each with the fault it would expose:
- Equal set and clear numbers on one bit: a design that gave clear the priority would drop the bit to 0.
- A zero event number aimed at unmapped slots: a design without the zero guard would set every unmapped bit.
- A write and a strobe in the same cycle: a design that forwarded the new entry would set the bit one strobe early.
- Out-of-range indices: a design that let these writes through would alias onto a real entry or return junk on readback.

Random traffic over a small number pool keeps multi-bit hits and set/clear collisions frequent.

// File: rtl/evmap_pkg.sv
package evmap_pkg;
  typedef enum logic {SEL_SET = 1'b0, SEL_CLR = 1'b1} ev_sel_e;
endpackage

// File: rtl/evmap_table.sv
module evmap_table #(
  parameter int NUM_BITS = 15,
  parameter int EV_W     = 16,
  parameter int IDX_W    = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               widx_i,
  input  logic                           wsel_i,
  input  logic [EV_W-1:0]                wdata_i,
  input  logic [IDX_W-1:0]               ridx_i,
  input  logic                           rsel_i,
  output logic [EV_W-1:0]                rdata_o,
  output logic [NUM_BITS-1:0][EV_W-1:0]  set_tbl_o,
  output logic [NUM_BITS-1:0][EV_W-1:0]  clr_tbl_o
);
  import evmap_pkg::*;

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_ent
    logic hit_w;
    assign hit_w = we_i && (widx_i == IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        set_tbl_o[i] <= '0;
        clr_tbl_o[i] <= '0;
      end else if (hit_w) begin
        if (ev_sel_e'(wsel_i) == SEL_SET) set_tbl_o[i] <= wdata_i;
        else                              clr_tbl_o[i] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_BITS; i++) begin
      if (ridx_i == IDX_W'(i)) rdata_o = rsel_i ? clr_tbl_o[i] : set_tbl_o[i];
    end
  end

  // R9: an out-of-range write leaves every entry untouched
  p_oor_write_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (int'(widx_i) >= NUM_BITS)) |=> ($stable(set_tbl_o) && $stable(clr_tbl_o)));
endmodule

// File: rtl/evmap_match.sv
module evmap_match #(
  parameter int NUM_BITS = 15,
  parameter int EV_W     = 16
) (
  input  logic                           ev_valid_i,
  input  logic [EV_W-1:0]                ev_num_i,
  input  logic [NUM_BITS-1:0][EV_W-1:0]  set_tbl_i,
  input  logic [NUM_BITS-1:0][EV_W-1:0]  clr_tbl_i,
  output logic [NUM_BITS-1:0]            hit_set_o,
  output logic [NUM_BITS-1:0]            hit_clr_o
);
  logic live;
  assign live = ev_valid_i && (ev_num_i != '0);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cmp
    assign hit_set_o[i] = live && (set_tbl_i[i] == ev_num_i);
    assign hit_clr_o[i] = live && (clr_tbl_i[i] == ev_num_i);
  end
endmodule

// File: rtl/evmap_cond_reg.sv
module evmap_cond_reg #(
  parameter int NUM_BITS = 15
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BITS-1:0]  hit_set_i,
  input  logic [NUM_BITS-1:0]  hit_clr_i,
  output logic [NUM_BITS-1:0]  cond_o
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cond_o[i] <= 1'b0;
      else if (hit_set_i[i]) cond_o[i] <= 1'b1;  // set wins
      else if (hit_clr_i[i]) cond_o[i] <= 1'b0;
    end

    p_set_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_set_i[i] |=> cond_o[i]);
    p_clr_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_clr_i[i] && !hit_set_i[i]) |=> !cond_o[i]);
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit_set_i[i] && !hit_clr_i[i]) |=> $stable(cond_o[i]));
  end
endmodule

// File: rtl/evmap_cond.sv
module evmap_cond #(
  parameter int NUM_BITS = 15,
  parameter int EV_W     = 16,
  localparam int IDX_W   = $clog2(NUM_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_widx_i,
  input  logic                 cfg_wsel_i,
  input  logic [EV_W-1:0]      cfg_wdata_i,
  input  logic [IDX_W-1:0]     cfg_ridx_i,
  input  logic                 cfg_rsel_i,
  output logic [EV_W-1:0]      cfg_rdata_o,
  input  logic                 ev_valid_i,
  input  logic [EV_W-1:0]      ev_num_i,
  output logic [NUM_BITS-1:0]  cond_o
);
  logic [NUM_BITS-1:0][EV_W-1:0] set_tbl, clr_tbl;
  logic [NUM_BITS-1:0]           hit_set, hit_clr;

  evmap_table #(.NUM_BITS(NUM_BITS), .EV_W(EV_W), .IDX_W(IDX_W)) u_table (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .widx_i(cfg_widx_i), .wsel_i(cfg_wsel_i), .wdata_i(cfg_wdata_i),
    .ridx_i(cfg_ridx_i), .rsel_i(cfg_rsel_i), .rdata_o(cfg_rdata_o),
    .set_tbl_o(set_tbl), .clr_tbl_o(clr_tbl)
  );

  evmap_match #(.NUM_BITS(NUM_BITS), .EV_W(EV_W)) u_match (
    .ev_valid_i, .ev_num_i, .set_tbl_i(set_tbl), .clr_tbl_i(clr_tbl),
    .hit_set_o(hit_set), .hit_clr_o(hit_clr)
  );

  evmap_cond_reg #(.NUM_BITS(NUM_BITS)) u_cond (
    .clk_i, .rst_ni, .hit_set_i(hit_set), .hit_clr_i(hit_clr), .cond_o
  );

  p_zero_ev_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_num_i == '0) |=> $stable(cond_o));
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_valid_i |=> $stable(cond_o));
  p_hit_onehot_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i |=> ((cond_o & ~$past(cond_o)) == ($past(hit_set) & ~$past(cond_o))));
endmodule

// File: tb/evmap_cond_bench.sv
module evmap_cond_bench;
  localparam int NB = 15;
  logic        clk = 0, rst_n = 0;
  logic        we = 0, wsel = 0, rsel = 0, evv = 0;
  logic [3:0]  widx = 0, ridx = 0;
  logic [15:0] wdata = 0, evn = 0, rdata;
  logic [14:0] cond;
  int checks = 0, errors = 0;
  logic [15:0] set_m [NB], clr_m [NB];
  logic [14:0] cond_m;

  always #4 clk = ~clk;

  evmap_cond u_evmap_cond (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_widx_i(widx), .cfg_wsel_i(wsel),
    .cfg_wdata_i(wdata), .cfg_ridx_i(ridx), .cfg_rsel_i(rsel), .cfg_rdata_o(rdata),
    .ev_valid_i(evv), .ev_num_i(evn), .cond_o(cond)
  );

  function automatic logic [14:0] next_cond(logic [14:0] c, logic v, logic [15:0] n);
    logic [14:0] r = c;
    if (v && n != 0)
      for (int i = 0; i < NB; i++) begin
        if (set_m[i] == n) r[i] = 1'b1;
        else if (clr_m[i] == n) r[i] = 1'b0;
      end
    return r;
  endfunction

  function automatic logic [15:0] exp_rd(int idx, logic sel);
    if (idx >= NB) return 16'h0;
    return sel ? clr_m[idx] : set_m[idx];
  endfunction

  task automatic chk_cond(string tag);
    checks++;
    if (cond !== cond_m) begin
      errors++;
      $display("FAIL %s: cond_o=%h expected %h", tag, cond, cond_m);
    end
  endtask

  task automatic chk_rd(int idx, logic sel, string tag);
    ridx = 4'(idx); rsel = sel; #1;
    checks++;
    if (rdata !== exp_rd(idx, sel)) begin
      errors++;
      $display("FAIL %s: rdata[%0d/%0d]=%h expected %h", tag, idx, sel, rdata, exp_rd(idx, sel));
    end
  endtask

  // one cycle: inputs applied away from the edge, model updated after it
  task automatic cyc(logic w, int wi, logic ws, logic [15:0] wd, logic v, logic [15:0] n);
    we = w; widx = 4'(wi); wsel = ws; wdata = wd; evv = v; evn = n;
    @(posedge clk); #2;
    cond_m = next_cond(cond_m, v, n);
    if (w && wi < NB) begin
      if (ws) clr_m[wi] = wd; else set_m[wi] = wd;
    end
    we = 0; evv = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NB; i++) begin set_m[i] = 0; clr_m[i] = 0; end
    cond_m = 0;
    #3 rst_n = 0; #20 rst_n = 1;
    @(posedge clk); #2;
    chk_cond("R1");
    for (int i = 0; i < NB; i++) begin chk_rd(i, 0, "R1"); chk_rd(i, 1, "R1"); end

    cyc(1, 0, 0, 16'd5, 0, 0); cyc(1, 0, 1, 16'd6, 0, 0);
    cyc(1, 1, 0, 16'd5, 0, 0); cyc(1, 1, 1, 16'd9, 0, 0);
    cyc(1, 2, 0, 16'd7, 0, 0); cyc(1, 2, 1, 16'd7, 0, 0);
    chk_rd(0, 0, "R2"); chk_rd(0, 1, "R2"); chk_rd(2, 1, "R2");
    cyc(0, 0, 0, 0, 1, 16'd5); chk_cond("R7"); chk_cond("R3");
    cyc(0, 0, 0, 0, 1, 16'd6); chk_cond("R4"); chk_cond("R8");
    cyc(0, 0, 0, 0, 1, 16'd7); chk_cond("R6");
    cyc(0, 0, 0, 0, 1, 16'd0); chk_cond("R5");
    cyc(0, 0, 0, 0, 0, 16'd9); chk_cond("R8");
    cyc(0, 0, 0, 0, 1, 16'd9); chk_cond("R4");
    cyc(1, 15, 0, 16'd6, 0, 0); chk_rd(15, 0, "R9"); chk_rd(15, 1, "R9");
    cyc(0, 0, 0, 0, 1, 16'd6); chk_cond("R9");
    cyc(1, 3, 0, 16'd11, 1, 16'd11); chk_cond("R10");
    cyc(0, 0, 0, 0, 1, 16'd11); chk_cond("R10");

    for (int k = 0; k < 4000; k++) begin
      logic w = ($urandom % 4) == 0;
      int   wi = $urandom % 16;
      logic ws = 1'($urandom);
      logic [15:0] wd = 16'($urandom % 8);
      logic v = 1'($urandom);
      logic [15:0] n = 16'($urandom % 8);
      cyc(w, wi, ws, wd, v, n);
      chk_cond("R8");
      if (k % 8 == 0) chk_rd($urandom % 16, 1'($urandom), "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule